// File: doc/BRIEF.md
# E1 Sa6 Code Pattern Detector

This block watches the Sa6 spare bit that the receive framer pulls out of each E1 frame that carries it. It packs the bits into 4-bit groups, with the earliest bit as the most significant, and sorts each group into one of five fixed codes or a single catch-all class. A class is accepted only when three groups in a row fall into it. Each acceptance sets a sticky bit in a 6-bit status word. A one-cycle read strobe returns the status and clears it. Whenever the accepted class differs from the one accepted before, a one-cycle interrupt pulse is raised.

Updating depends on the alignment flags. While frame alignment is lost, the block freezes its status and interrupt, and discards any partial group and any run in progress. In synchronous mode, groups start on a submultiframe boundary marker, and updates need multiframe alignment as well. In asynchronous mode, groups run free and the multiframe flag is ignored.

Top module: `e1_sa6_detect`

## Requirements
- R1: Four Sa6 bits, qualified by `sa6_valid`, form one group. The first received bit is the group's most significant bit.
- R2: The class encodings map to status bits as follows. 1000 maps to bit 0, 1010 to bit 1, 1100 to bit 2, 1110 to bit 3 and 1111 to bit 4. Every other 4-bit value maps to bit 5.
- R3: A class sets its status bit only when the group just completed is the third or later consecutive group of that class. Two groups in a row set nothing.
- R4: A status bit stays set until a read, even after the input has moved on to another accepted class.
- R5: A `rd_stb` cycle clears all status bits on the next edge. If an acceptance lands in the same cycle, its bit remains set after the clear.
- R6: `irq_o` pulses for one cycle when an accepted class differs from the previously accepted class. Reset sets the previous class to "none", so the first acceptance after reset pulses. Accepting the same class again does not pulse.
- R7: While `fas_ok` is low, status and `irq_o` do not change, except for clearing by a read. The partial group and the run counter are discarded.
- R8: With `sync_mode` high, a bit presented with `smf_start` starts a new group. While `mfa_ok` is low, nothing is accepted, and the partial group and the run counter are discarded.
- R9: With `sync_mode` low, `mfa_ok` and `smf_start` have no effect.
- R10: After reset, the status is 0 and `irq_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sa6_valid | input | 1 | Strobe: `sa6_bit` carries a new Sa6 bit |
| sa6_bit | input | 1 | Received Sa6 bit |
| smf_start | input | 1 | The current bit is the first of a submultiframe |
| fas_ok | input | 1 | Basic frame alignment held |
| mfa_ok | input | 1 | Multiframe alignment held |
| sync_mode | input | 1 | 1: groups follow the submultiframe; 0: free running |
| rd_stb | input | 1 | Status read strobe, clears the status |
| status_o | output | 6 | Sticky accepted-class bits |
| irq_o | output | 1 | One-cycle pulse when the accepted class changes |

## Verification
The bench drives every code three times in a row. It also drives runs of two, which must set nothing, and a catch-all run built from three different non-fixed values. It re-accepts a class to show that no second interrupt is raised. It issues a read in exactly the cycle an acceptance lands: a design that let the clear win would lose the new bit. It leaves two stray bits before a frame-alignment loss. A design that kept them would shift every later group and never accept. It also checks that a dropped multiframe flag, or a misaligned stray bit before a boundary marker, is handled per mode. A design that ignored `smf_start` would misgroup the bits, and one that ignored `sync_mode` would either block or accept at the wrong time.

// File: rtl/sa6_pkg.sv
package sa6_pkg;
  localparam int unsigned SA6_GRP_W = 4;
  localparam int unsigned SA6_NCLS  = 6;

  typedef enum logic [2:0] {
    CLS_8    = 3'd0,
    CLS_A    = 3'd1,
    CLS_C    = 3'd2,
    CLS_E    = 3'd3,
    CLS_F    = 3'd4,
    CLS_OTH  = 3'd5,
    CLS_NONE = 3'd7
  } sa6_cls_e;

  // Sort one 4-bit group (first bit in MSB) into a class.
  function automatic sa6_cls_e sa6_classify(input logic [SA6_GRP_W-1:0] code);
    case (code)
      4'b1000: return CLS_8;
      4'b1010: return CLS_A;
      4'b1100: return CLS_C;
      4'b1110: return CLS_E;
      4'b1111: return CLS_F;
      default: return CLS_OTH;
    endcase
  endfunction

  // One-hot status mask for a class; "none" gives zero.
  function automatic logic [SA6_NCLS-1:0] sa6_mask(input sa6_cls_e cls);
    logic [SA6_NCLS-1:0] m;
    for (int i = 0; i < SA6_NCLS; i++) m[i] = (int'(cls) == i);
    return m;
  endfunction
endpackage

// File: rtl/sa6_shifter.sv
module sa6_shifter #(
  parameter int unsigned GROUP_BITS = 4,
  localparam int unsigned CW = $clog2(GROUP_BITS + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  bit_vld,
  input  logic                  bit_in,
  input  logic                  align_start,
  input  logic                  align_en,
  output logic                  grp_vld,
  output logic [GROUP_BITS-1:0] grp_code
);
  logic [GROUP_BITS-1:0] sh;
  logic [CW-1:0]         cnt;
  logic                  restart;
  logic                  last_bit;

  assign restart  = bit_vld && align_en && align_start;
  assign last_bit = bit_vld && !restart && (cnt == CW'(GROUP_BITS - 1));

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      sh       <= '0;
      cnt      <= '0;
      grp_vld  <= 1'b0;
      grp_code <= '0;
    end else begin
      grp_vld <= 1'b0;
      if (restart) begin
        sh  <= GROUP_BITS'(bit_in);
        cnt <= CW'(1);
      end else if (last_bit) begin
        grp_code <= {sh[GROUP_BITS-2:0], bit_in};
        grp_vld  <= 1'b1;
        sh       <= '0;
        cnt      <= '0;
      end else if (bit_vld) begin
        sh  <= {sh[GROUP_BITS-2:0], bit_in};
        cnt <= cnt + CW'(1);
      end
    end
  end

  // R1: a group completes only from a clocked-in bit
  a_r1_group_from_bit: assert property (@(posedge clk) disable iff (!rst_n)
    grp_vld |-> $past(bit_vld));
  // R1: groups are never back to back
  a_r1_group_spacing: assert property (@(posedge clk) disable iff (!rst_n)
    grp_vld |=> !grp_vld);
endmodule

// File: rtl/sa6_run.sv
module sa6_run
  import sa6_pkg::*;
#(
  parameter int unsigned RUN_LEN = 3,
  localparam int unsigned RW = $clog2(RUN_LEN + 1)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 clr,
  input  logic                 grp_vld,
  input  logic [SA6_GRP_W-1:0] grp_code,
  output logic                 hit_vld,
  output sa6_cls_e             hit_cls
);
  sa6_cls_e      prev_cls;
  sa6_cls_e      cur_cls;
  logic [RW-1:0] run;
  logic [RW-1:0] run_nxt;

  always_comb begin
    cur_cls = sa6_classify(grp_code);
    if (cur_cls == prev_cls && run != '0)
      run_nxt = (run == RW'(RUN_LEN)) ? run : run + RW'(1);
    else
      run_nxt = RW'(1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      run      <= '0;
      prev_cls <= CLS_NONE;
      hit_vld  <= 1'b0;
      hit_cls  <= CLS_NONE;
    end else begin
      hit_vld <= 1'b0;
      if (grp_vld) begin
        run      <= run_nxt;
        prev_cls <= cur_cls;
        hit_cls  <= cur_cls;
        hit_vld  <= (run_nxt == RW'(RUN_LEN));
      end
    end
  end

  // R2: a hit always names a real class
  a_r2_hit_class: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |-> (hit_cls != CLS_NONE));
  // R3: a hit only follows a completed group
  a_r3_hit_after_group: assert property (@(posedge clk) disable iff (!rst_n)
    hit_vld |-> $past(grp_vld));
  // R3: run counter never exceeds its limit
  a_r3_run_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run <= RW'(RUN_LEN));
endmodule

// File: rtl/e1_sa6_detect.sv
module e1_sa6_detect
  import sa6_pkg::*;
#(
  parameter int unsigned RUN_LEN = 3
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                sa6_valid,
  input  logic                sa6_bit,
  input  logic                smf_start,
  input  logic                fas_ok,
  input  logic                mfa_ok,
  input  logic                sync_mode,
  input  logic                rd_stb,
  output logic [SA6_NCLS-1:0] status_o,
  output logic                irq_o
);
  logic                 upd_en;
  logic                 grp_vld;
  logic [SA6_GRP_W-1:0] grp_code;
  logic                 hit_vld;
  sa6_cls_e             hit_cls;
  logic                 hit_ok;
  sa6_cls_e             last_cls;

  assign upd_en = fas_ok && (!sync_mode || mfa_ok);
  assign hit_ok = hit_vld && upd_en;

  sa6_shifter #(.GROUP_BITS(SA6_GRP_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .clr        (!upd_en),
    .bit_vld    (sa6_valid),
    .bit_in     (sa6_bit),
    .align_start(smf_start),
    .align_en   (sync_mode),
    .grp_vld    (grp_vld),
    .grp_code   (grp_code)
  );

  sa6_run #(.RUN_LEN(RUN_LEN)) u_run (
    .clk     (clk),
    .rst_n   (rst_n),
    .clr     (!upd_en),
    .grp_vld (grp_vld),
    .grp_code(grp_code),
    .hit_vld (hit_vld),
    .hit_cls (hit_cls)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status_o <= '0;
      irq_o    <= 1'b0;
      last_cls <= CLS_NONE;
    end else begin
      status_o <= (rd_stb ? '0 : status_o) | (hit_ok ? sa6_mask(hit_cls) : '0);
      irq_o    <= hit_ok && (hit_cls != last_cls);
      if (hit_ok) last_cls <= hit_cls;
    end
  end

  // R3: an accepted hit shows in status on the next edge
  a_r3_hit_sets: assert property (@(posedge clk) disable iff (!rst_n)
    hit_ok |=> ((status_o & sa6_mask($past(hit_cls))) != '0));
  // R4: without a read, no set bit is lost
  a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> ((status_o & $past(status_o)) == $past(status_o)));
  // R5: a read with no hit leaves status empty
  a_r5_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_stb && !hit_ok) |=> (status_o == '0));
  // R6: interrupt is a single-cycle pulse
  a_r6_irq_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |=> !irq_o);
  // R7: no interrupt and no new bit while frame alignment is lost
  a_r7_no_irq: assert property (@(posedge clk) disable iff (!rst_n)
    !fas_ok |=> !irq_o);
  a_r7_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    (!fas_ok && !rd_stb) |=> (status_o == $past(status_o)));
  // R8: synchronous mode without multiframe alignment raises nothing
  a_r8_mfa_gate: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_mode && !mfa_ok) |=> !irq_o);
endmodule

// File: tb/e1_sa6_detect_tb.sv
`timescale 1ns/1ps
module e1_sa6_detect_tb;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sa6_valid = 1'b0, sa6_bit = 1'b0, smf_start = 1'b0;
  logic fas_ok = 1'b1, mfa_ok = 1'b1, sync_mode = 1'b0, rd_stb = 1'b0;
  logic [5:0] status_o;
  logic irq_o;
  int n_run = 0, n_fail = 0, irq_cnt = 0;
  bit done = 0;

  always #10 clk = ~clk;

  e1_sa6_detect u_dut (
    .clk(clk), .rst_n(rst_n), .sa6_valid(sa6_valid), .sa6_bit(sa6_bit),
    .smf_start(smf_start), .fas_ok(fas_ok), .mfa_ok(mfa_ok),
    .sync_mode(sync_mode), .rd_stb(rd_stb), .status_o(status_o), .irq_o(irq_o)
  );

  always @(negedge clk) if (rst_n && irq_o) irq_cnt++;

  // {code, repeats, expected status, expected irq pulses}
  localparam int NV = 9;
  localparam logic [12:0] VECS [NV] = '{
    {4'b1000, 2'd3, 6'h01, 1'b1},
    {4'b1010, 2'd3, 6'h02, 1'b1},
    {4'b1100, 2'd3, 6'h04, 1'b1},
    {4'b1110, 2'd3, 6'h08, 1'b1},
    {4'b1111, 2'd3, 6'h10, 1'b1},
    {4'b0110, 2'd3, 6'h20, 1'b1},
    {4'b0110, 2'd3, 6'h20, 1'b0},
    {4'b1000, 2'd2, 6'h00, 1'b0},
    {4'b1010, 2'd3, 6'h02, 1'b1}
  };

  task automatic chk(input string req, input int act, input int exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic send_bit(input logic b, input logic smf);
    @(negedge clk);
    sa6_valid = 1'b1; sa6_bit = b; smf_start = smf;
  endtask

  task automatic idle(input int n);
    @(negedge clk);
    sa6_valid = 1'b0; smf_start = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic send_grp(input logic [3:0] c, input logic smf);
    for (int i = 3; i >= 0; i--) send_bit(c[i], (i == 3) ? smf : 1'b0);
    idle(0);
  endtask

  task automatic send_n(input logic [3:0] c, input int n, input logic smf);
    for (int k = 0; k < n; k++) send_grp(c, smf);
    idle(3);
  endtask

  task automatic do_read();
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
  endtask

  initial begin
    #(20ns * 150000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    int irq0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R10 status after reset", status_o, 0);
    chk("R10 irq after reset", irq_o, 0);

    // Table: R1 MSB-first grouping, R2 encodings, R3 three-in-a-row, R6 irq
    for (int v = 0; v < NV; v++) begin
      irq0 = irq_cnt;
      send_n(VECS[v][12:9], int'(VECS[v][8:7]), 1'b0);
      chk($sformatf("R1/R2/R3 vec %0d status", v), status_o, int'(VECS[v][6:1]));
      chk($sformatf("R6 vec %0d irq", v), irq_cnt - irq0, int'(VECS[v][0]));
      do_read();
      chk($sformatf("R5 vec %0d cleared", v), status_o, 0);
    end

    // R2: mixed non-fixed values form one catch-all class
    send_grp(4'b0000, 1'b0); send_grp(4'b0101, 1'b0); send_grp(4'b1001, 1'b0);
    idle(3);
    chk("R2 mixed other class", status_o, 6'h20);
    do_read();

    // R4: sticky across a class change
    send_n(4'b1100, 3, 1'b0);
    send_n(4'b1000, 3, 1'b0);
    idle(5);
    chk("R4 sticky both bits", status_o, 6'h05);
    do_read();

    // R5: read in the same cycle as an acceptance
    send_n(4'b1000, 3, 1'b0);
    chk("R5 preset bit", status_o, 6'h01);
    send_grp(4'b1110, 1'b0); send_grp(4'b1110, 1'b0);
    for (int i = 3; i >= 0; i--) send_bit(i != 0, 1'b0);
    @(negedge clk); sa6_valid = 1'b0;
    @(negedge clk); rd_stb = 1'b1;
    @(negedge clk); rd_stb = 1'b0;
    chk("R5 acceptance wins over clear", status_o, 6'h08);
    do_read();

    // R7: frozen while frame alignment lost
    irq0 = irq_cnt;
    fas_ok = 1'b0;
    send_n(4'b1111, 3, 1'b0);
    chk("R7 no status while unaligned", status_o, 0);
    chk("R7 no irq while unaligned", irq_cnt - irq0, 0);
    fas_ok = 1'b1;
    // R7: run counter discarded
    send_n(4'b1010, 2, 1'b0);
    @(negedge clk); fas_ok = 1'b0; @(negedge clk); fas_ok = 1'b1;
    send_n(4'b1010, 1, 1'b0);
    chk("R7 run cleared", status_o, 0);
    send_n(4'b1010, 2, 1'b0);
    chk("R7 fresh run accepted", status_o, 6'h02);
    do_read();
    // R7: partial group discarded
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); idle(0);
    @(negedge clk); fas_ok = 1'b0; @(negedge clk); fas_ok = 1'b1;
    send_n(4'b1000, 3, 1'b0);
    chk("R7 partial group cleared", status_o, 6'h01);
    do_read();

    // R8: synchronous mode aligns on the boundary marker
    sync_mode = 1'b1;
    send_bit(1'b1, 1'b0); idle(0);
    send_n(4'b1010, 3, 1'b1);
    chk("R8 aligned to submultiframe", status_o, 6'h02);
    do_read();
    irq0 = irq_cnt;
    mfa_ok = 1'b0;
    send_n(4'b1100, 3, 1'b1);
    chk("R8 blocked without mfa", status_o, 0);
    chk("R8 no irq without mfa", irq_cnt - irq0, 0);
    mfa_ok = 1'b1;
    send_n(4'b1100, 2, 1'b1);
    @(negedge clk); mfa_ok = 1'b0; @(negedge clk); mfa_ok = 1'b1;
    send_n(4'b1100, 1, 1'b1);
    chk("R8 run cleared on mfa loss", status_o, 0);

    // R9: asynchronous mode ignores mfa and boundary marker
    sync_mode = 1'b0; mfa_ok = 1'b0;
    irq0 = irq_cnt;
    send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0); send_bit(1'b1, 1'b0);
    send_bit(1'b0, 1'b1); idle(0);
    send_n(4'b1110, 2, 1'b1);
    chk("R9 accepted without mfa", status_o, 6'h08);
    chk("R9 irq on change", irq_cnt - irq0, 1);
    mfa_ok = 1'b1;

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule